// File: doc/BRIEF.md
# Serial Status-Register Command Front End

This block is the serial slave side of an EEPROM-style device, reduced to the instructions that handle the status register. The instructions are: set the write-enable latch, clear it, read the status byte, and write it. The serial pins are oversampled by a system clock through a short synchronizer. Each serial clock rising edge shifts in one data bit, most significant bit first, while chip select is low. The first eight bits form the opcode.

A status write commits only when chip select rises in the single gap between the sixteenth and seventeenth serial clock rising edges. The latch must also be set. A committed write starts a self-timed busy period. During that period the old protection bits stay in force, the status byte can still be read, and every other instruction is dropped. When the period ends, the written bits take effect and the latch clears.

The two protection bits leave on `bp_o` for a memory-array controller.

Top module: `spi_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, `bp_o` is 0 and `spi_sdo_oe_o` is low.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1). Opcode 0x04 clears it. Each takes effect only when chip select rises after exactly eight serial clock rising edges.
- R3: A status write (opcode 0x01) whose latch is clear leaves the status byte unchanged.
- R4: A status write commits only when chip select rises after exactly 16 rising edges. With 15 or 17 edges it is discarded.
- R5: A committed write stores data bits 7, 3 and 2 into status bits 7, 3 and 2. Status bits 6 to 4 always read 0. Data bits 6 to 4, 1 and 0 have no effect.
- R6: The busy flag (status bit 0) is 1 for exactly TW_CYCLES clock cycles from the cycle after the commit.
- R7: `bp_o` (status bits 3:2) keeps its old value throughout the busy period. It takes the written value when the period ends, in the same cycle that the latch clears.
- R8: While busy, every opcode other than 0x05 is ignored.
- R9: Opcode 0x05 drives the status byte on `spi_sdo_o`, MSB first, one bit per serial clock falling edge. The first bit follows the falling edge after the eighth opcode bit. The byte repeats while chip select stays low, and it is readable while busy.
- R10: Raising chip select clears the bit count. A latch opcode followed by a ninth bit before chip select rises is discarded.
- R11: `spi_sdo_oe_o` is high only while chip select is low during a read-status instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_sck_i | input | 1 | Serial clock |
| spi_cs_ni | input | 1 | Chip select, active low |
| spi_sdi_i | input | 1 | Serial data in |
| spi_sdo_o | output | 1 | Serial data out |
| spi_sdo_oe_o | output | 1 | Output enable for spi_sdo_o |
| bp_o | output | 2 | Block-protect bits in force |

## Verification
The bench builds the block with TW_CYCLES at 600 and SYNC_STAGES at 2. The busy period is then long enough to fit a dropped latch-clear command and a full two-byte status read inside it, but short enough to wait out many times. The serial clock runs at twelve system clocks per bit, so chip select can be placed precisely between the sixteenth and seventeenth edges, or one edge early or late. A behavioural model in the bench follows the synchronizer delay and checks `bp_o`, the output enable and the serial output on every clock.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
  localparam int unsigned OP_W       = 8;
  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned STAT_W     = 8;
  localparam int unsigned LOCK_BIT   = 7;
  localparam int unsigned BP_HI      = 3;
  localparam int unsigned BP_LO      = 2;
  localparam int unsigned BP_W       = BP_HI - BP_LO + 1;

  typedef enum logic [OP_W-1:0] {
    OP_WRSR = 8'h01,
    OP_WRDI = 8'h04,
    OP_RDSR = 8'h05,
    OP_WREN = 8'h06
  } sr_op_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic sdi_i,
  output logic cs_s_o,
  output logic sdi_s_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_rise_o
);
  // bit 2 = sck, bit 1 = cs_n, bit 0 = sdi
  localparam logic [2:0] IDLE_PINS = 3'b010;

  logic [2:0] chain_q [STAGES];
  logic [2:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) chain_q[i] <= IDLE_PINS;
      prev_q <= IDLE_PINS;
    end else begin
      chain_q[0] <= {sck_i, cs_ni, sdi_i};
      for (int i = 1; i < int'(STAGES); i++) chain_q[i] <= chain_q[i-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign cs_s_o     = chain_q[STAGES-1][1];
  assign sdi_s_o    = chain_q[STAGES-1][0];
  assign sck_rise_o = chain_q[STAGES-1][2] & ~prev_q[2];
  assign sck_fall_o = ~chain_q[STAGES-1][2] & prev_q[2];
  assign cs_rise_o  = chain_q[STAGES-1][1] & ~prev_q[1];
endmodule

// File: rtl/spi_shift_in.sv
module spi_shift_in #(
  parameter int unsigned OP_W       = 8,
  parameter int unsigned FRAME_BITS = 16,
  localparam int unsigned CNT_MAX   = FRAME_BITS + 1,
  localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_s_i,
  input  logic             sck_rise_i,
  input  logic             sdi_i,
  output logic [CNT_W-1:0] bit_cnt_o,
  output logic [OP_W-1:0]  shreg_o,
  output logic [OP_W-1:0]  opcode_o,
  output logic             op_valid_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [OP_W-1:0]  sr_q, op_q;
  logic             opv_q;
  logic [OP_W-1:0]  sr_next;

  assign sr_next = {sr_q[OP_W-2:0], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sr_q  <= '0;
      op_q  <= '0;
      opv_q <= 1'b0;
    end else if (cs_s_i) begin
      cnt_q <= '0;
      opv_q <= 1'b0;
    end else if (sck_rise_i) begin
      sr_q <= sr_next;
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(OP_W - 1)) begin
        op_q  <= sr_next;
        opv_q <= 1'b1;
      end
    end
  end

  assign bit_cnt_o  = cnt_q;
  assign shreg_o    = sr_q;
  assign opcode_o   = op_q;
  assign op_valid_o = opv_q;
endmodule

// File: rtl/sr_write_timer.sv
module sr_write_timer #(
  parameter int unsigned TW_CYCLES = 5000,
  localparam int unsigned TW_W     = (TW_CYCLES > 1) ? $clog2(TW_CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic [TW_W-1:0] left_q;
  logic            busy_q;

  assign done_o = busy_q && (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      left_q <= TW_W'(TW_CYCLES - 1);
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/sr_serial_out.sv
module sr_serial_out #(
  parameter int unsigned W   = 8,
  localparam int unsigned IDX_W = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_s_i,
  input  logic         sck_fall_i,
  input  logic         reading_i,
  input  logic [W-1:0] word_i,
  output logic         sdo_o
);
  logic [IDX_W-1:0] idx_q;
  logic             sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= IDX_W'(W - 1);
      sdo_q <= 1'b0;
    end else if (cs_s_i) begin
      idx_q <= IDX_W'(W - 1);
    end else if (sck_fall_i && reading_i) begin
      sdo_q <= word_i[idx_q];
      idx_q <= (idx_q == '0) ? IDX_W'(W - 1) : idx_q - 1'b1;
    end
  end

  assign sdo_o = sdo_q;
endmodule

// File: rtl/spi_status_ctrl.sv
module spi_status_ctrl
  import spi_sr_pkg::*;
#(
  parameter int unsigned TW_CYCLES   = 5000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            spi_sck_i,
  input  logic            spi_cs_ni,
  input  logic            spi_sdi_i,
  output logic            spi_sdo_o,
  output logic            spi_sdo_oe_o,
  output logic [BP_W-1:0] bp_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 2);

  logic             cs_s, sdi_s, sck_rise, sck_fall, cs_rise;
  logic [CNT_W-1:0] bit_cnt;
  logic [OP_W-1:0]  shreg, opcode;
  logic             op_valid;
  logic             busy, tmr_done;
  logic             wel_q, lock_q, pend_lock_q;
  logic [BP_W-1:0]  bp_q, pend_bp_q;
  logic [STAT_W-1:0] stat_w;
  logic             cmd_ok, wren_go, wrdi_go, wrsr_go, reading;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .sck_i(spi_sck_i), .cs_ni(spi_cs_ni), .sdi_i(spi_sdi_i),
    .cs_s_o(cs_s), .sdi_s_o(sdi_s),
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .cs_rise_o(cs_rise)
  );

  spi_shift_in #(.OP_W(OP_W), .FRAME_BITS(FRAME_BITS)) u_shift (
    .clk_i, .rst_ni,
    .cs_s_i(cs_s), .sck_rise_i(sck_rise), .sdi_i(sdi_s),
    .bit_cnt_o(bit_cnt), .shreg_o(shreg), .opcode_o(opcode), .op_valid_o(op_valid)
  );

  sr_write_timer #(.TW_CYCLES(TW_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(wrsr_go), .busy_o(busy), .done_o(tmr_done)
  );

  // commit only on the chip-select rise, only when idle
  assign cmd_ok  = cs_rise && !busy && op_valid;
  assign wren_go = cmd_ok && bit_cnt == CNT_W'(OP_W) && opcode == OP_WREN;
  assign wrdi_go = cmd_ok && bit_cnt == CNT_W'(OP_W) && opcode == OP_WRDI;
  assign wrsr_go = cmd_ok && bit_cnt == CNT_W'(FRAME_BITS) && opcode == OP_WRSR && wel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q       <= 1'b0;
      lock_q      <= 1'b0;
      bp_q        <= '0;
      pend_lock_q <= 1'b0;
      pend_bp_q   <= '0;
    end else begin
      if (wrsr_go) begin
        pend_lock_q <= shreg[LOCK_BIT];
        pend_bp_q   <= shreg[BP_HI:BP_LO];
      end
      if (tmr_done) begin
        lock_q <= pend_lock_q;
        bp_q   <= pend_bp_q;
        wel_q  <= 1'b0;
      end else if (wren_go) begin
        wel_q <= 1'b1;
      end else if (wrdi_go) begin
        wel_q <= 1'b0;
      end
    end
  end

  assign stat_w  = {lock_q, 3'b000, bp_q, wel_q, busy};
  assign reading = !cs_s && op_valid && opcode == OP_RDSR;

  sr_serial_out #(.W(STAT_W)) u_out (
    .clk_i, .rst_ni,
    .cs_s_i(cs_s), .sck_fall_i(sck_fall), .reading_i(reading),
    .word_i(stat_w), .sdo_o(spi_sdo_o)
  );

  assign spi_sdo_oe_o = reading;
  assign bp_o         = bp_q;
endmodule

// File: rtl/spi_status_ctrl_chk.sv
module spi_status_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy,
  input logic       tmr_done,
  input logic       wel,
  input logic       cs_s,
  input logic [7:0] opcode,
  input logic [1:0] bp_o,
  input logic       sdo_oe_o
);
  a_r7_bp_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !tmr_done |=> $stable(bp_o));
  a_r8_wel_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !tmr_done |=> $stable(wel));
  a_r7_wel_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_done |=> !wel);
  a_r6_busy_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_done |=> !busy);
  a_r3_start_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wel));
  a_r11_oe_only_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> (opcode == 8'h05 && !cs_s));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_idle: assert (bp_o == 2'b00 && !sdo_oe_o && !busy);
    end
  end
endmodule

bind spi_status_ctrl spi_status_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy(busy), .tmr_done(tmr_done),
  .wel(wel_q), .cs_s(cs_s), .opcode(opcode), .bp_o(bp_o), .sdo_oe_o(spi_sdo_oe_o)
);

// File: tb/sim_spi_status_ctrl.sv
module sim_spi_status_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int TW         = 600;
  localparam int SYNC       = 2;

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, sdi = 0;
  logic sdo, oe;
  logic [1:0] bp;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_status_ctrl #(.TW_CYCLES(TW), .SYNC_STAGES(SYNC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .spi_sck_i(sck), .spi_cs_ni(cs_n), .spi_sdi_i(sdi),
    .spi_sdo_o(sdo), .spi_sdo_oe_o(oe), .bp_o(bp)
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model: pin history {sck,cs_n,sdi}, newest first
  logic [2:0] hist[$];
  int m_cnt, m_sr, m_op, m_opv, m_wel, m_wip, m_tleft, m_b7, m_bp, m_pb7, m_pbp, m_sdo, m_idx;
  bit m_oe;

  function automatic int m_stat();
    return (m_b7 << 7) | (m_bp << 2) | (m_wel << 1) | m_wip;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      for (int i = 0; i <= SYNC; i++) hist.push_back(3'b010);
      m_cnt = 0; m_sr = 0; m_op = 0; m_opv = 0; m_wel = 0; m_wip = 0; m_tleft = 0;
      m_b7 = 0; m_bp = 0; m_pb7 = 0; m_pbp = 0; m_sdo = 0; m_idx = 7;
      m_oe = 0;
    end else begin
      logic [2:0] s, p;
      bit rise, fall, csr, done, go;
      int st, nsr;
      s = hist[SYNC-1]; p = hist[SYNC];
      rise = s[2] && !p[2]; fall = !s[2] && p[2]; csr = s[1] && !p[1];
      st = m_stat();
      done = m_wip && m_tleft == 0;
      go = csr && !m_wip && m_opv;
      // commands and self-timed write
      if (done) begin
        m_wip = 0; m_b7 = m_pb7; m_bp = m_pbp; m_wel = 0;
      end else begin
        if (m_wip) m_tleft--;
        if (go && m_cnt == 8 && m_op == 6) m_wel = 1;
        if (go && m_cnt == 8 && m_op == 4) m_wel = 0;
        if (go && m_cnt == 16 && m_op == 1 && m_wel) begin
          m_wip = 1; m_tleft = TW - 1;
          m_pb7 = (m_sr >> 7) & 1; m_pbp = (m_sr >> 2) & 3;
        end
      end
      // serial out from pre-edge state
      if (s[1]) m_idx = 7;
      else if (fall && m_opv && m_op == 5) begin
        m_sdo = (st >> m_idx) & 1;
        m_idx = (m_idx == 0) ? 7 : m_idx - 1;
      end
      // serial in
      if (s[1]) begin
        m_cnt = 0; m_opv = 0;
      end else if (rise) begin
        nsr = ((m_sr << 1) | s[0]) & 8'hFF;
        if (m_cnt == 7) begin m_op = nsr; m_opv = 1; end
        m_sr = nsr;
        if (m_cnt < 17) m_cnt++;
      end
      hist.push_front({sck, cs_n, sdi});
      void'(hist.pop_back());
      m_oe = !hist[SYNC-1][1] && m_opv && m_op == 5;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R7 bp_o", bp, m_bp);
      chk("R11 oe", oe, m_oe);
      if (m_oe) chk("R9 sdo", sdo, m_sdo);
    end
  end

  task automatic wait_clk(int n); repeat (n) @(negedge clk); endtask
  task automatic pulse(bit b); sdi = b; wait_clk(HALF); sck = 1; wait_clk(HALF); sck = 0; endtask
  task automatic send(logic [15:0] v, int n);
    for (int i = n - 1; i >= 0; i--) pulse(v[i]);
  endtask
  task automatic fr_begin(); cs_n = 0; wait_clk(HALF); endtask
  task automatic fr_end(); wait_clk(2); cs_n = 1; wait_clk(2 * HALF); endtask
  task automatic cmd(logic [7:0] op, int extra);
    fr_begin(); send(16'(op), 8); send(16'h0, extra); fr_end();
  endtask
  task automatic wrsr(logic [7:0] d, int nbits);
    fr_begin(); send(16'h01, 8);
    if (nbits >= 8) begin send(16'(d), 8); send(16'h0, nbits - 8); end
    else send(16'(d >> (8 - nbits)), nbits);
    fr_end();
  endtask
  task automatic rdsr(output logic [7:0] b0, output logic [7:0] b1);
    logic [15:0] v;
    fr_begin(); send(16'h05, 8);
    for (int i = 15; i >= 0; i--) begin
      sdi = 0; wait_clk(HALF); v[i] = sdo;
      sck = 1; wait_clk(HALF); sck = 0;
    end
    fr_end();
    b0 = v[15:8]; b1 = v[7:0];
  endtask

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [7:0] a, b;
    wait_clk(4); rst_n = 1; wait_clk(4);
    chk("R1 bp", bp, 0); chk("R1 oe", oe, 0);
    rdsr(a, b); chk("R1 status", a, 8'h00);
    wrsr(8'h8C, 8); rdsr(a, b); chk("R3 no latch", a, 8'h00);
    cmd(8'h06, 0); rdsr(a, b); chk("R2 set latch", a, 8'h02);
    cmd(8'h04, 0); rdsr(a, b); chk("R2 clear latch", a, 8'h00);
    cmd(8'h06, 1); rdsr(a, b); chk("R10 nine bits", a, 8'h00);
    cmd(8'h06, 0);
    wrsr(8'hFF, 9); rdsr(a, b); chk("R4 seventeen edges", a, 8'h02);
    wrsr(8'hFF, 7); rdsr(a, b); chk("R4 fifteen edges", a, 8'h02);
    wrsr(8'hFF, 8);
    cmd(8'h04, 0);
    rdsr(a, b); chk("R6 busy read", a, 8'h03); chk("R8 clear ignored", b, 8'h03);
    chk("R7 old bp", bp, 0);
    wait_clk(TW);
    rdsr(a, b); chk("R5 written", a, 8'h8C); chk("R9 repeat", b, 8'h8C);
    chk("R7 new bp", bp, 3);
    cmd(8'h06, 0); wrsr(8'h77, 8);
    chk("R11 oe low", oe, 0);
    wait_clk(TW + 20);
    rdsr(a, b); chk("R5 masked", a, 8'h04); chk("R7 bp 01", bp, 1);
    wrsr(8'h00, 8); wait_clk(TW);
    rdsr(a, b); chk("R3 latch cleared", a, 8'h04);
    summary();
  end
endmodule